// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block carries an 18-bit word between an A side and a B side, with one independent path for each direction. Every path owns one storage word that behaves as a transparent latch while its latch enable is high. While the latch enable is low it behaves as an edge-triggered register: it loads on the falling edge of that path's transfer strobe and holds at any steady strobe level. Each destination port has a tri-state driver modelled as a data bus plus an enable output. The A-to-B enable input is active high and the B-to-A enable input is active low.

All inputs are sampled by one core clock, so the strobes are treated as data: a strobe edge is recognised when two consecutive core-clock samples differ. Transparent data leaves through a combinational path, and captured data appears one core-clock edge after the strobe edge is sampled. An asynchronous active-low reset clears both storage words.

Top module: `ubt_transceiver`

## Requirements
- R1: While `ab_le` is high and `ab_oe` is high, `b_out` equals `a_in` in the same cycle.
- R2: While `ab_le` stays low and `ab_stb` stays at one level, whether high or low, `b_out` keeps its value even when `a_in` changes.
- R3: While `ab_le` is low, a sample of `ab_stb` at 0 that follows a sample at 1 loads the `a_in` value present at that sample into the A-to-B store, and `b_out` shows that value from the next cycle.
- R4: A rising `ab_stb` (sample 0 followed by sample 1) with `ab_le` low loads nothing.
- R5: When `ab_le` goes from high to low, the store keeps the last value that passed through transparently.
- R6: `b_oe` is high exactly when `ab_oe` is high (active high); while it is low, `b_out` is all zeros.
- R7: `a_oe` is high exactly when `ba_oe_n` is low (active low); while it is low, `a_out` is all zeros.
- R8: The B-to-A path applies the rules of R1 to R5 to `b_in`, `ba_le` and `ba_stb`, and drives `a_out`.
- R9: Asserting `rst_n` low clears both stores to zero, so a latched output read right after reset is zero.
- R10: No input of one direction changes the output of the other direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples every control input |
| rst_n | input | 1 | Asynchronous active-low reset of both stores |
| a_in | input | 18 | Data arriving at the A side |
| b_in | input | 18 | Data arriving at the B side |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable, transparent when high |
| ab_stb | input | 1 | A-to-B transfer strobe, loads on its falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when high |
| ba_stb | input | 1 | B-to-A transfer strobe, loads on its falling edge |
| a_out | output | 18 | Data driven onto the A side, zero when disabled |
| a_oe | output | 1 | A-side driver enable |
| b_out | output | 18 | Data driven onto the B side, zero when disabled |
| b_oe | output | 1 | B-side driver enable |

## Verification
The properties assume that every input, strobes included, changes only between core-clock edges and holds each level for at least one full core-clock period. Under that assumption a strobe edge is seen as two samples that differ. They also assume reset has been inactive for two cycles before any edge-dependent rule applies. The stimulus drives every input on the falling core-clock edge and changes each strobe at most once per cycle, so strobe edges are never shorter than one sample. Edge-dependent expectations start only after reset has been released on a falling core-clock edge.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   // which strobe transition loads the store
   typedef enum logic {
      UBT_EDGE_FALL = 1'b0,
      UBT_EDGE_RISE = 1'b1
   } ubt_edge_e;

   // polarity of a direction's enable input
   typedef enum logic {
      UBT_OE_HIGH = 1'b0,
      UBT_OE_LOW  = 1'b1
   } ubt_oe_pol_e;

   localparam int UBT_DEF_WIDTH = 18;
endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det
   import ubt_pkg::*;
#(
   parameter ubt_edge_e EDGE = UBT_EDGE_FALL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= strobe;
   end

   generate
      if (EDGE == UBT_EDGE_FALL) begin : g_fall
         assign hit = prev_q & ~strobe;
      end else begin : g_rise
         assign hit = ~prev_q & strobe;
      end
   endgenerate
endmodule

// File: rtl/ubt_store_cell.sv
module ubt_store_cell #(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             pass,
   input  logic             load,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] held_q;
   logic             upd;

   assign upd = pass | load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= '0;
      else if (upd) held_q <= d;
   end

   // transparent path bypasses the register
   assign q = pass ? d : held_q;
endmodule

// File: rtl/ubt_out_drv.sv
module ubt_out_drv
   import ubt_pkg::*;
#(
   parameter int          WIDTH = 18,
   parameter ubt_oe_pol_e POL   = UBT_OE_HIGH
) (
   input  logic             en_pin,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             oe
);
   logic en_int;

   generate
      if (POL == UBT_OE_HIGH) begin : g_act_hi
         assign en_int = en_pin;
      end else begin : g_act_lo
         assign en_int = ~en_pin;
      end
   endgenerate

   assign oe = en_int;
   assign q  = en_int ? d : '0;
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
   import ubt_pkg::*;
#(
   parameter int          WIDTH = 18,
   parameter ubt_edge_e   EDGE  = UBT_EDGE_FALL,
   parameter ubt_oe_pol_e POL   = UBT_OE_HIGH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] src,
   input  logic             le,
   input  logic             stb,
   input  logic             en_pin,
   output logic [WIDTH-1:0] dst,
   output logic             dst_oe
);
   logic             load;
   logic [WIDTH-1:0] cell_q;

   ubt_edge_det #(.EDGE(EDGE)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(stb),
      .hit   (load)
   );

   ubt_store_cell #(.WIDTH(WIDTH)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (src),
      .pass (le),
      .load (load),
      .q    (cell_q)
   );

   ubt_out_drv #(.WIDTH(WIDTH), .POL(POL)) u_drv (
      .en_pin(en_pin),
      .d     (cell_q),
      .q     (dst),
      .oe    (dst_oe)
   );
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
   import ubt_pkg::*;
#(
   parameter int        WIDTH = UBT_DEF_WIDTH,
   parameter ubt_edge_e EDGE  = UBT_EDGE_FALL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ab_oe,
   input  logic             ab_le,
   input  logic             ab_stb,
   input  logic             ba_oe_n,
   input  logic             ba_le,
   input  logic             ba_stb,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);
   localparam int MAX_WIDTH = 1024;

   generate
      if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("ubt_transceiver: WIDTH %0d outside 1..%0d", WIDTH, MAX_WIDTH);
      end
   endgenerate

   ubt_lane #(.WIDTH(WIDTH), .EDGE(EDGE), .POL(UBT_OE_HIGH)) u_ab (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (a_in),
      .le    (ab_le),
      .stb   (ab_stb),
      .en_pin(ab_oe),
      .dst   (b_out),
      .dst_oe(b_oe)
   );

   ubt_lane #(.WIDTH(WIDTH), .EDGE(EDGE), .POL(UBT_OE_LOW)) u_ba (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (b_in),
      .le    (ba_le),
      .stb   (ba_stb),
      .en_pin(ba_oe_n),
      .dst   (a_out),
      .dst_oe(a_oe)
   );
endmodule

// File: rtl/ubt_transceiver_chk.sv
module ubt_transceiver_chk #(
   parameter int WIDTH = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             ab_oe,
   input logic             ab_le,
   input logic             ab_stb,
   input logic             ba_oe_n,
   input logic             ba_le,
   input logic             ba_stb,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);
   // R1
   ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_le && b_oe) |-> (b_out == a_in));

   // R2
   ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_le && $past(!ab_le) && ab_oe && $past(ab_oe) &&
       (ab_stb == $past(ab_stb)) && ($past(ab_stb) == $past(ab_stb, 2)))
      |-> $stable(b_out));

   // R3
   ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_le && $past(!ab_le) && ab_oe && $past(rst_n) && $past(rst_n, 2) &&
       $past(ab_stb, 2) && !$past(ab_stb))
      |-> (b_out == $past(a_in)));

   // R4
   ab_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_le && $past(!ab_le) && ab_oe && $past(ab_oe) && !$past(ab_stb, 2))
      |-> $stable(b_out));

   // R6
   b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_out != '0) |-> (b_oe && ab_oe));

   // R7
   a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_out != '0) |-> (a_oe && !ba_oe_n));

   // R8
   ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_le && !ba_oe_n) |-> (a_out == b_in));

   // R9
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && !ab_le && ab_oe) |-> (b_out == '0));
endmodule

bind ubt_transceiver ubt_transceiver_chk #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .a_in   (a_in),
   .b_in   (b_in),
   .ab_oe  (ab_oe),
   .ab_le  (ab_le),
   .ab_stb (ab_stb),
   .ba_oe_n(ba_oe_n),
   .ba_le  (ba_le),
   .ba_stb (ba_stb),
   .a_out  (a_out),
   .a_oe   (a_oe),
   .b_out  (b_out),
   .b_oe   (b_oe)
);

// File: tb/tb_ubt_transceiver.sv
`timescale 1ns/1ps
module tb_ubt_transceiver;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         ab_oe = 1'b0, ab_le = 1'b0, ab_stb = 1'b0;
   logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_stb = 1'b0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [W-1:0] a_val;
      logic         a_en;
      logic [W-1:0] b_val;
      logic         b_en;
      string        tag;
   } exp_t;

   exp_t sb[$];

   // reference state
   logic [W-1:0] m_ab = '0, m_ba = '0;
   logic         m_pab = 1'b0, m_pba = 1'b0;

   always #5 clk = ~clk;

   ubt_transceiver dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_oe(ab_oe), .ab_le(ab_le), .ab_stb(ab_stb),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the expected result
   task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic le1, input logic st1, input logic oe1,
                       input logic le2, input logic st2, input logic oe2n,
                       input string tag);
      exp_t e;
      @(negedge clk);
      a_in = a; b_in = b;
      ab_le = le1; ab_stb = st1; ab_oe = oe1;
      ba_le = le2; ba_stb = st2; ba_oe_n = oe2n;
      if (le1 || (m_pab && !st1)) m_ab = a;
      if (le2 || (m_pba && !st2)) m_ba = b;
      m_pab = st1;
      m_pba = st2;
      e.b_en  = oe1;
      e.b_val = oe1 ? m_ab : '0;
      e.a_en  = !oe2n;
      e.a_val = !oe2n ? m_ba : '0;
      e.tag   = tag;
      sb.push_back(e);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " b_out"}, b_out, e.b_val);
            check({e.tag, " b_oe"}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, e.b_en});
            check({e.tag, " a_out"}, a_out, e.a_val);
            check({e.tag, " a_oe"}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, e.a_en});
         end
      end
   end

   initial begin
      logic [W-1:0] lf;
      // reset state with both drivers disabled (R6, R7)
      a_in = 18'h2A5A5; b_in = 18'h15A5A;
      repeat (3) @(negedge clk);
      check("R6 reset b_out", b_out, '0);
      check("R7 reset a_out", a_out, '0);
      check("R6 reset b_oe", {{(W-1){1'b0}}, b_oe}, '0);
      check("R7 reset a_oe", {{(W-1){1'b0}}, a_oe}, '0);
      rst_n = 1'b1;
      // R9 stores cleared: latched mode, drivers on
      step(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0, 0, 0, "R9");
      step(18'h12345, 18'h0ABCD, 0, 0, 1, 0, 0, 0, "R9");
      // R1 transparent A to B
      step(18'h00001, 18'h00000, 1, 0, 1, 0, 0, 0, "R1");
      step(18'h3FFFE, 18'h00000, 1, 0, 1, 0, 0, 0, "R1");
      step(18'h15555, 18'h00000, 1, 1, 1, 0, 0, 0, "R1");
      step(18'h2AAAA, 18'h00000, 1, 0, 1, 0, 0, 0, "R1 fall while transparent");
      // R5 latch enable drops, keeps last transparent value
      step(18'h0F0F0, 18'h00000, 0, 0, 1, 0, 0, 0, "R5");
      step(18'h33333, 18'h00000, 0, 0, 1, 0, 0, 0, "R2 static low");
      // R4 rising strobe loads nothing
      step(18'h11111, 18'h00000, 0, 1, 1, 0, 0, 0, "R4");
      step(18'h22222, 18'h00000, 0, 1, 1, 0, 0, 0, "R2 static high");
      // R3 falling strobe loads
      step(18'h0BEEF, 18'h00000, 0, 0, 1, 0, 0, 0, "R3");
      step(18'h01234, 18'h00000, 0, 0, 1, 0, 0, 0, "R2 hold after load");
      step(18'h04321, 18'h00000, 0, 1, 1, 0, 0, 0, "R4");
      step(18'h3C3C3, 18'h00000, 0, 0, 1, 0, 0, 0, "R3");
      // R6 driver disable
      step(18'h3C3C3, 18'h00000, 0, 0, 0, 0, 0, 0, "R6");
      step(18'h3C3C3, 18'h00000, 0, 0, 1, 0, 0, 0, "R6 reenable");
      // R8 B to A modes
      step(18'h3C3C3, 18'h1ACE1, 0, 0, 1, 1, 0, 0, "R8 transparent");
      step(18'h3C3C3, 18'h2BEAD, 0, 0, 1, 0, 0, 0, "R8 latch drop");
      step(18'h3C3C3, 18'h00777, 0, 0, 1, 0, 1, 0, "R8 rise");
      step(18'h3C3C3, 18'h00888, 0, 0, 1, 0, 1, 0, "R8 static high");
      step(18'h3C3C3, 18'h09999, 0, 0, 1, 0, 0, 0, "R8 fall load");
      step(18'h3C3C3, 18'h0AAAA, 0, 0, 1, 0, 0, 0, "R8 static low");
      // R7 active-low enable
      step(18'h3C3C3, 18'h0AAAA, 0, 0, 1, 0, 0, 1, "R7");
      step(18'h3C3C3, 18'h0AAAA, 0, 0, 1, 1, 0, 1, "R7 transparent disabled");
      step(18'h3C3C3, 18'h0AAAA, 0, 0, 1, 1, 0, 0, "R7 reenable");
      // R10 one direction busy, other held
      step(18'h11111, 18'h05555, 1, 1, 1, 0, 0, 0, "R10");
      step(18'h22222, 18'h06666, 0, 0, 1, 0, 0, 0, "R10");
      step(18'h33333, 18'h07777, 0, 1, 1, 0, 0, 0, "R10");
      step(18'h33333, 18'h08888, 0, 0, 1, 1, 1, 0, "R10");
      // mixed pseudo-random traffic
      lf = 18'h1D2C3;
      for (int i = 0; i < 200; i++) begin
         lf = {lf[W-2:0], lf[17] ^ lf[10]};
         step(lf, ~lf, lf[0], lf[1], lf[2] | lf[3], lf[4], lf[5], lf[6] & lf[7],
              "R10 mixed");
      end
      repeat (3) @(negedge clk);
      check("R10 queue drained", {{(W-1){1'b0}}, (sb.size() == 0)}, {{(W-1){1'b0}}, 1'b1});
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule